// File: doc/BRIEF.md
# Read-After-Write Interlock for an In-Order Five-Stage Pipeline

This block is the interlock logic for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that has no bypass network. It looks at the two source register numbers of the instruction waiting in the fetch/decode latch. Each source has a flag that says whether the instruction really reads it. The block compares each source with the destination register and write-enable held in the three downstream latches: decode/execute, execute/memory and memory/writeback. That gives six qualified comparisons.

When any comparison shows a live read-after-write dependence, the block freezes the front of the pipe. It stops the PC update and the fetch/decode latch load, and it steers the control mux so that the fields entering decode/execute become a nop bubble. The decision is purely combinational from the current latch contents. The pipe therefore holds for exactly as many cycles as a producer with a matching register stays in one of the three downstream latches, and it advances in the first cycle that no match remains.

The output side is organised as two named actions. ADVANCE is taken when no stage reports a hit, and HOLD is taken when at least one does. ADVANCE goes to HOLD in the cycle a hit appears (hazard seen). HOLD goes back to ADVANCE in the cycle the last hit disappears (hazard cleared). Neither action has any memory.

Top module: `hz_stall_unit`

## Requirements
- R1: A source that is used and nonzero, and equals the decode/execute destination while that stage's write-enable is 1, causes a stall. This applies to source 1 and to source 2.
- R2: The same match against the execute/memory destination and write-enable causes a stall.
- R3: The same match against the memory/writeback destination and write-enable causes a stall.
- R4: A matching destination whose write-enable is 0 never causes a stall.
- R5: A source whose used flag is 0 never causes a stall, even when its number matches a writing destination.
- R6: Register number 0 never causes a stall, whatever the flags.
- R7: During a stall pc_write_en and ifid_write_en are both 0. Without a stall both are 1.
- R8: bubble_sel is 1 exactly when the block stalls, and 0 otherwise.
- R9: The outputs follow the current inputs within the same cycle, so a stall ends in the first cycle that no qualified match remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src1_reg | input | REG_W | First source register number in fetch/decode |
| src1_used | input | 1 | First source is read by the instruction |
| src2_reg | input | REG_W | Second source register number in fetch/decode |
| src2_used | input | 1 | Second source is read by the instruction |
| idex_dst | input | REG_W | Destination register held in decode/execute |
| idex_wen | input | 1 | Decode/execute instruction writes a register |
| exmem_dst | input | REG_W | Destination register held in execute/memory |
| exmem_wen | input | 1 | Execute/memory instruction writes a register |
| memwb_dst | input | REG_W | Destination register held in memory/writeback |
| memwb_wen | input | 1 | Memory/writeback instruction writes a register |
| pc_write_en | output | 1 | PC may update (0 during a stall) |
| ifid_write_en | output | 1 | Fetch/decode latch may load (0 during a stall) |
| bubble_sel | output | 1 | Select nop control fields into decode/execute |

## Verification
There is no register between inputs and outputs, so every result is due in the same cycle as its stimulus. The bench changes the inputs one time unit after each rising edge and samples all three outputs at the following falling edge. At that point the logic has settled and no next edge has arrived. A behavioural model scans the three producer slots in a loop and is compared on every cycle. This runs across directed cases for each stage, source, qualifier and register zero, then a hold-then-release sequence, then randomised traffic over a small register range so that matches are frequent.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Number of downstream latches a source is compared against
    localparam int unsigned NUM_STAGES = 3;
    // Number of source specifiers per instruction
    localparam int unsigned NUM_SRC    = 2;

    // Action taken by the front of the pipe this cycle
    typedef enum logic {
        ACT_ADVANCE = 1'b0,
        ACT_HOLD    = 1'b1
    } pipe_act_e;

endpackage

// File: rtl/hz_src_cmp.sv
module hz_src_cmp #(
    parameter int unsigned REG_W = 5
) (
    input  logic [REG_W-1:0] prod_dst,
    input  logic             prod_wen,
    input  logic [REG_W-1:0] cons_reg,
    input  logic             cons_used,
    output logic             hit
);

    logic same_reg;
    logic nonzero;

    always_comb begin
        same_reg = (prod_dst == cons_reg);
        nonzero  = |cons_reg;
        hit      = prod_wen && cons_used && nonzero && same_reg;
    end

endmodule

// File: rtl/hz_stage_cmp.sv
module hz_stage_cmp #(
    parameter int unsigned REG_W   = 5,
    parameter int unsigned NUM_SRC = 2
) (
    input  logic [REG_W-1:0]         prod_dst,
    input  logic                     prod_wen,
    input  logic [NUM_SRC*REG_W-1:0] src_regs,
    input  logic [NUM_SRC-1:0]       src_used,
    output logic                     stage_hit
);

    logic [NUM_SRC-1:0] src_hit;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        hz_src_cmp #(.REG_W(REG_W)) u_cmp (
            .prod_dst (prod_dst),
            .prod_wen (prod_wen),
            .cons_reg (src_regs[s*REG_W +: REG_W]),
            .cons_used(src_used[s]),
            .hit      (src_hit[s])
        );
    end

    assign stage_hit = |src_hit;

endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
    import hz_pkg::*;
#(
    parameter int unsigned N_STG = 3
) (
    input  logic [N_STG-1:0] stage_hit,
    output logic             pc_we,
    output logic             ifid_we,
    output logic             nop_sel
);

    pipe_act_e act;

    // Action selection: HOLD whenever any stage reports a hit
    always_comb begin
        act = (|stage_hit) ? ACT_HOLD : ACT_ADVANCE;
    end

    // Output decode per action
    always_comb begin
        pc_we   = 1'b1;
        ifid_we = 1'b1;
        nop_sel = 1'b0;
        unique case (act)
            ACT_ADVANCE: begin
                pc_we   = 1'b1;
                ifid_we = 1'b1;
                nop_sel = 1'b0;
            end
            ACT_HOLD: begin
                pc_we   = 1'b0;
                ifid_we = 1'b0;
                nop_sel = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit
    import hz_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input  logic [REG_W-1:0] src1_reg,
    input  logic             src1_used,
    input  logic [REG_W-1:0] src2_reg,
    input  logic             src2_used,
    input  logic [REG_W-1:0] idex_dst,
    input  logic             idex_wen,
    input  logic [REG_W-1:0] exmem_dst,
    input  logic             exmem_wen,
    input  logic [REG_W-1:0] memwb_dst,
    input  logic             memwb_wen,
    output logic             pc_write_en,
    output logic             ifid_write_en,
    output logic             bubble_sel
);

    localparam int unsigned SRC_BITS = NUM_SRC * REG_W;
    localparam int unsigned DST_BITS = NUM_STAGES * REG_W;

    logic [SRC_BITS-1:0]   src_flat;
    logic [NUM_SRC-1:0]    used_flat;
    logic [DST_BITS-1:0]   dst_flat;
    logic [NUM_STAGES-1:0] wen_flat;
    logic [NUM_STAGES-1:0] stage_hit;

    assign src_flat  = {src2_reg, src1_reg};
    assign used_flat = {src2_used, src1_used};
    assign dst_flat  = {memwb_dst, exmem_dst, idex_dst};
    assign wen_flat  = {memwb_wen, exmem_wen, idex_wen};

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        hz_stage_cmp #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_stage (
            .prod_dst (dst_flat[g*REG_W +: REG_W]),
            .prod_wen (wen_flat[g]),
            .src_regs (src_flat),
            .src_used (used_flat),
            .stage_hit(stage_hit[g])
        );
    end

    hz_stall_ctrl #(.N_STG(NUM_STAGES)) u_ctrl (
        .stage_hit(stage_hit),
        .pc_we    (pc_write_en),
        .ifid_we  (ifid_write_en),
        .nop_sel  (bubble_sel)
    );

endmodule

// File: rtl/hz_stall_checker.sv
module hz_stall_checker #(
    parameter int unsigned REG_W = 5
) (
    input logic [REG_W-1:0] src1_reg,
    input logic             src1_used,
    input logic [REG_W-1:0] src2_reg,
    input logic             src2_used,
    input logic [REG_W-1:0] idex_dst,
    input logic             idex_wen,
    input logic [REG_W-1:0] exmem_dst,
    input logic             exmem_wen,
    input logic [REG_W-1:0] memwb_dst,
    input logic             memwb_wen,
    input logic             pc_write_en,
    input logic             ifid_write_en,
    input logic             bubble_sel
);

    always_comb begin
        AST_FREEZE_PAIR: assert (pc_write_en == ifid_write_en); // R7
        AST_BUBBLE_MATCH: assert (bubble_sel == !pc_write_en); // R8
        AST_NO_WRITERS: assert (!(!idex_wen && !exmem_wen && !memwb_wen) || !bubble_sel); // R4
        AST_NO_READERS: assert (!(!src1_used && !src2_used) || !bubble_sel); // R5
        AST_ZERO_SRCS: assert (!(src1_reg == '0 && src2_reg == '0) || !bubble_sel); // R6
        AST_IDEX_HIT: assert (!(src1_used && idex_wen && src1_reg != '0 && idex_dst == src1_reg) || bubble_sel); // R1
        AST_EXMEM_HIT: assert (!(src2_used && exmem_wen && src2_reg != '0 && exmem_dst == src2_reg) || bubble_sel); // R2
        AST_MEMWB_HIT: assert (!(src1_used && memwb_wen && src1_reg != '0 && memwb_dst == src1_reg) || bubble_sel); // R3
    end

endmodule

bind hz_stall_unit hz_stall_checker #(.REG_W(REG_W)) u_chk (
    .src1_reg     (src1_reg),
    .src1_used    (src1_used),
    .src2_reg     (src2_reg),
    .src2_used    (src2_used),
    .idex_dst     (idex_dst),
    .idex_wen     (idex_wen),
    .exmem_dst    (exmem_dst),
    .exmem_wen    (exmem_wen),
    .memwb_dst    (memwb_dst),
    .memwb_wen    (memwb_wen),
    .pc_write_en  (pc_write_en),
    .ifid_write_en(ifid_write_en),
    .bubble_sel   (bubble_sel)
);

// File: tb/hz_stall_unit_tb.sv
module hz_stall_unit_tb;

    localparam int REG_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [REG_W-1:0] src1_reg = '0, src2_reg = '0;
    logic             src1_used = 1'b0, src2_used = 1'b0;
    logic [REG_W-1:0] idex_dst = '0, exmem_dst = '0, memwb_dst = '0;
    logic             idex_wen = 1'b0, exmem_wen = 1'b0, memwb_wen = 1'b0;
    logic             pc_write_en, ifid_write_en, bubble_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    hz_stall_unit #(.REG_W(REG_W)) u_dut (
        .src1_reg     (src1_reg),
        .src1_used    (src1_used),
        .src2_reg     (src2_reg),
        .src2_used    (src2_used),
        .idex_dst     (idex_dst),
        .idex_wen     (idex_wen),
        .exmem_dst    (exmem_dst),
        .exmem_wen    (exmem_wen),
        .memwb_dst    (memwb_dst),
        .memwb_wen    (memwb_wen),
        .pc_write_en  (pc_write_en),
        .ifid_write_en(ifid_write_en),
        .bubble_sel   (bubble_sel)
    );

    // Behavioural reference: scan producers, qualify each source
    function automatic bit ref_stall();
        int dst[3];
        bit wen[3];
        int src[2];
        bit use_[2];
        bit stall = 1'b0;
        dst[0] = idex_dst;  wen[0] = idex_wen;
        dst[1] = exmem_dst; wen[1] = exmem_wen;
        dst[2] = memwb_dst; wen[2] = memwb_wen;
        src[0] = src1_reg;  use_[0] = src1_used;
        src[1] = src2_reg;  use_[1] = src2_used;
        for (int p = 0; p < 3; p++)
            for (int s = 0; s < 2; s++)
                if (wen[p] && use_[s] && src[s] != 0 && src[s] == dst[p])
                    stall = 1'b1;
        return stall;
    endfunction

    task automatic check(input string tag);
        bit exp_stall = ref_stall();
        logic [2:0] act = {pc_write_en, ifid_write_en, bubble_sel};
        logic [2:0] exp = {!exp_stall, !exp_stall, exp_stall};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {pc,ifid,bubble} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic apply(input int s1, input bit u1, input int s2, input bit u2,
                         input int d0, input bit w0, input int d1, input bit w1,
                         input int d2, input bit w2, input string tag);
        @(posedge clk); #1;
        src1_reg = REG_W'(s1); src1_used = u1;
        src2_reg = REG_W'(s2); src2_used = u2;
        idex_dst = REG_W'(d0); idex_wen = w0;
        exmem_dst = REG_W'(d1); exmem_wen = w1;
        memwb_dst = REG_W'(d2); memwb_wen = w2;
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 reset idle advance");
        apply(5,1, 9,1, 5,1, 0,0, 0,0, "R1 idex src1");
        apply(4,1, 9,1, 9,1, 0,0, 0,0, "R1 idex src2");
        apply(7,1, 3,1, 0,0, 7,1, 0,0, "R2 exmem src1");
        apply(7,1, 12,1, 0,0, 12,1, 0,0, "R2 exmem src2");
        apply(6,1, 31,1, 0,0, 0,0, 31,1, "R3 memwb src2");
        apply(8,1, 2,1, 0,0, 0,0, 8,1, "R3 memwb src1");
        apply(5,1, 5,1, 5,0, 5,0, 5,0, "R4 no writer");
        apply(5,0, 6,1, 5,1, 0,0, 0,0, "R5 src1 unused");
        apply(1,1, 6,0, 0,0, 0,0, 6,1, "R5 src2 unused");
        apply(0,1, 0,1, 0,1, 0,1, 0,1, "R6 register zero");
        apply(10,1, 0,0, 10,1, 0,0, 0,0, "R8 hold bubble");
        apply(10,1, 0,0, 0,0, 10,1, 0,0, "R9 hold moves down");
        apply(10,1, 0,0, 0,0, 0,0, 10,1, "R9 hold last stage");
        apply(10,1, 0,0, 0,0, 0,0, 0,0, "R9 release first clear cycle");
        for (int i = 0; i < 400; i++) begin
            apply($urandom_range(0,3), 1'($urandom_range(0,1)),
                  $urandom_range(0,3), 1'($urandom_range(0,1)),
                  $urandom_range(0,3), 1'($urandom_range(0,1)),
                  $urandom_range(0,3), 1'($urandom_range(0,1)),
                  $urandom_range(0,3), 1'($urandom_range(0,1)),
                  "R9 random traffic");
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule